// File: doc/BRIEF.md
# Interrupt Status and Timer Register Block

This block is a small memory-mapped register file on a simple 64-bit bus. It holds an interrupt enable mask, an interrupt status word, a scratch word, a free-running counter and a compare value. It drives two level outputs. The first, a processor interrupt, is high whenever an enabled status bit is pending. The second is a timer condition, which is high once the counter has caught up with the compare value and the timer enable bit of the mask is set.

Software can change the status word through three addresses. One address loads the whole word. A second clears the bits given in the data. A third reads the word back and also clears the bits given in the data when written. A single-cycle tick strobe advances the counter by a fixed step of 1000. A constant memory-configuration word can be read at a fixed offset.

The bus side uses a two-state machine. ST_IDLE waits for a request. The transition ST_IDLE to ST_RESP fires on an accepted read. ST_RESP presents the read data for one cycle. From ST_RESP the machine returns to ST_IDLE when no read is requested, or stays in ST_RESP when a new read arrives at once. A write never leaves ST_IDLE.

Top module: `irq_tmr_regs`

## Requirements
- R1: While rst_n is low and after it rises, mask, status, scratch, counter and compare are zero, and irq, timer_irq and bus_rvalid are low.
- R2: A read is accepted in any cycle with bus_en=1 and bus_we=0. bus_rvalid is high in the following cycle, and in that cycle bus_rdata carries the value the register held before that clock edge. In any other cycle bus_rvalid is low.
- R3: The mask at byte offset 0x10000 reads back the last value written to it.
- R4: A write to 0x10020 loads the status word with the write data. Reads of 0x10020 and 0x10028 return zero.
- R5: A write to 0x10028 clears each status bit that is 1 in the write data and leaves the other bits as they were.
- R6: A read of 0x10030 returns the status word. A write to 0x10030 clears each status bit that is 1 in the write data.
- R7: irq is high exactly when (status AND mask) is nonzero. It reflects a register write from the cycle after that write's clock edge.
- R8: The counter at 0x20000 is readable and writable. Each cycle with tick=1 adds 1000, modulo 2^64. When a counter write and a tick fall in the same cycle, the written value is kept and the tick is lost.
- R9: The compare value at 0x30000 is readable and writable. timer_irq is high exactly when mask bit 50 is 1 and the counter is greater than or equal to the compare value, both taken as unsigned.
- R10: A read of 0x20 returns 0x0000000080010000. Writes to 0x20 have no effect.
- R11: The scratch word at 0x10018 reads back the last value written to it.
- R12: A read of any other offset returns zero. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 18 | Byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| tick | input | 1 | Counter advance strobe |
| irq | output | 1 | Level interrupt to the processor |
| timer_irq | output | 1 | Timer condition qualified by mask bit 50 |

## Verification
The assertions check the following on every clock:
- the read response timing;
- the constant configuration word;
- the counter step, and the priority of a counter write over a tick;
- that clearing writes leave none of the named status bits set;
- that a zero mask silences both interrupt lines.

Only the bench's scenarios can show the rest:
- the full read-back values of mask, scratch, compare and status through their aliases;
- the exact boundary where the counter reaches the compare value;
- the behaviour of timer_irq when mask bit 50 is off;
- that writes to unmapped offsets and to the configuration word change nothing.

The bench shows these by comparing every cycle against a behavioural model.

// File: rtl/irq_tmr_pkg.sv
package irq_tmr_pkg;

    // Byte offsets of the mapped words
    localparam int unsigned OFF_CFG     = 32'h0000_0020;
    localparam int unsigned OFF_MASK    = 32'h0001_0000;
    localparam int unsigned OFF_SCRATCH = 32'h0001_0018;
    localparam int unsigned OFF_ST_SET  = 32'h0001_0020;
    localparam int unsigned OFF_ST_CLR  = 32'h0001_0028;
    localparam int unsigned OFF_ST_W1C  = 32'h0001_0030;
    localparam int unsigned OFF_COUNT   = 32'h0002_0000;
    localparam int unsigned OFF_CMP     = 32'h0003_0000;

    localparam longint unsigned CFG_WORD = 64'h0000_0000_8001_0000;

    typedef struct packed {
        logic cfg;
        logic mask;
        logic scratch;
        logic st_set;
        logic st_clr;
        logic st_w1c;
        logic count;
        logic cmp;
    } sel_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

endpackage

// File: rtl/irq_tmr_decode.sv
module irq_tmr_decode
    import irq_tmr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    logic [31:0] a32;

    assign a32 = 32'(addr);

    always_comb begin
        sel         = '0;
        sel.cfg     = (a32 == OFF_CFG);
        sel.mask    = (a32 == OFF_MASK);
        sel.scratch = (a32 == OFF_SCRATCH);
        sel.st_set  = (a32 == OFF_ST_SET);
        sel.st_clr  = (a32 == OFF_ST_CLR);
        sel.st_w1c  = (a32 == OFF_ST_W1C);
        sel.count   = (a32 == OFF_COUNT);
        sel.cmp     = (a32 == OFF_CMP);
    end
endmodule

// File: rtl/irq_tmr_status.sv
module irq_tmr_status
    import irq_tmr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  sel_t              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] scratch_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            status_q  <= '0;
            scratch_q <= '0;
        end else if (wr) begin
            if (sel.mask)    mask_q    <= wdata;
            if (sel.scratch) scratch_q <= wdata;
            if (sel.st_set)
                status_q <= wdata;
            else if (sel.st_clr || sel.st_w1c)
                status_q <= status_q & ~wdata;
        end
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/irq_tmr_counter.sv
module irq_tmr_counter
    import irq_tmr_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int STEP      = 1000,
    parameter int TIMER_BIT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  sel_t              sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              timer_irq
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            cmp_q   <= '0;
        end else begin
            if (wr && sel.count)
                count_q <= wdata;
            else if (tick)
                count_q <= count_q + STEP_V;
            if (wr && sel.cmp)
                cmp_q <= wdata;
        end
    end

    assign timer_irq = mask[TIMER_BIT] && (count_q >= cmp_q);
endmodule

// File: rtl/irq_tmr_bus_fsm.sv
module irq_tmr_bus_fsm
    import irq_tmr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req)  state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata <= rd_value;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RESP: rvalid = 1'b1;
            default: rvalid = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_tmr_regs.sv
module irq_tmr_regs
    import irq_tmr_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 18,
    parameter int STEP      = 1000,
    parameter int TIMER_BIT = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              tick,
    output logic              irq,
    output logic              timer_irq
);
    localparam logic [DATA_W-1:0] CFG_V = DATA_W'(CFG_WORD);

    sel_t              sel;
    logic              wr, rd;
    logic [DATA_W-1:0] mask_q, status_q, scratch_q, count_q, cmp_q;
    logic [DATA_W-1:0] rd_value;

    assign wr = bus_en &&  bus_we;
    assign rd = bus_en && !bus_we;

    irq_tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    irq_tmr_status #(.DATA_W(DATA_W)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .scratch_q (scratch_q),
        .irq       (irq)
    );

    irq_tmr_counter #(.DATA_W(DATA_W), .STEP(STEP), .TIMER_BIT(TIMER_BIT)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .tick      (tick),
        .mask      (mask_q),
        .count_q   (count_q),
        .cmp_q     (cmp_q),
        .timer_irq (timer_irq)
    );

    always_comb begin
        rd_value = '0;
        if (sel.cfg)     rd_value = CFG_V;
        if (sel.mask)    rd_value = mask_q;
        if (sel.scratch) rd_value = scratch_q;
        if (sel.st_w1c)  rd_value = status_q;
        if (sel.count)   rd_value = count_q;
        if (sel.cmp)     rd_value = cmp_q;
    end

    irq_tmr_bus_fsm #(.DATA_W(DATA_W)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd),
        .rd_value (rd_value),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );
endmodule

// File: rtl/irq_tmr_regs_chk.sv
module irq_tmr_regs_chk
    import irq_tmr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 18,
    parameter int STEP   = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              tick,
    input logic              irq,
    input logic              timer_irq,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] status_q
);
    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);
    localparam logic [DATA_W-1:0] CFG_V  = DATA_W'(CFG_WORD);

    logic [31:0] a32;
    logic        rd, wr_cnt, wr_clr, wr_mask0;

    assign a32      = 32'(bus_addr);
    assign rd       = bus_en && !bus_we;
    assign wr_cnt   = bus_en && bus_we && (a32 == OFF_COUNT);
    assign wr_clr   = bus_en && bus_we && ((a32 == OFF_ST_CLR) || (a32 == OFF_ST_W1C));
    assign wr_mask0 = bus_en && bus_we && (a32 == OFF_MASK) && (bus_wdata == '0);

    // R2: read response appears in the next cycle and only then
    p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);
    p_rvalid_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !bus_rvalid);

    // R10: configuration word is constant
    p_cfg_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && a32 == OFF_CFG) |=> (bus_rdata == CFG_V));

    // R8: tick step and write priority
    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt) |=> (count_q == $past(count_q) + STEP_V));
    p_count_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count_q == $past(bus_wdata)));

    // R5 / R6: named bits are gone after a clearing write
    p_clear_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((status_q & $past(bus_wdata)) == '0));

    // R7 / R9: zero mask silences both lines
    p_mask_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask0 |=> (!irq && !timer_irq));
endmodule

bind irq_tmr_regs irq_tmr_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .tick      (tick),
    .irq       (irq),
    .timer_irq (timer_irq),
    .count_q   (count_q),
    .status_q  (status_q)
);

// File: tb/irq_tmr_regs_tb.sv
module irq_tmr_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_en, bus_we, tick;
    logic [17:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata;
    logic        bus_rvalid, irq, timer_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // behavioural model state
    logic [63:0] m_mask, m_status, m_scratch, m_cnt, m_cmp;
    logic        e_rv;
    logic [63:0] e_rd;
    string       e_req;

    irq_tmr_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .tick      (tick),
        .irq       (irq),
        .timer_irq (timer_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] m_read(input logic [17:0] a);
        case (a)
            18'h00020: return 64'h0000_0000_8001_0000;
            18'h10000: return m_mask;
            18'h10018: return m_scratch;
            18'h10030: return m_status;
            18'h20000: return m_cnt;
            18'h30000: return m_cmp;
            default:   return 64'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [17:0] a);
        case (a)
            18'h00020: return "R10";
            18'h10000: return "R3";
            18'h10018: return "R11";
            18'h10020, 18'h10028: return "R4";
            18'h10030: return "R6";
            18'h20000: return "R8";
            18'h30000: return "R9";
            default:   return "R12";
        endcase
    endfunction

    // one bus cycle: drive, advance model, compare after the edge
    task automatic cyc(input logic en, input logic we, input logic [17:0] a,
                       input logic [63:0] d, input logic tk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; tick = tk;
        e_rv = en && !we;
        if (e_rv) begin
            e_rd  = m_read(a);
            e_req = req_of(a);
        end
        if (en && we) begin
            case (a)
                18'h10000: m_mask = d;
                18'h10018: m_scratch = d;
                18'h10020: m_status = d;
                18'h10028, 18'h10030: m_status = m_status & ~d;
                18'h30000: m_cmp = d;
                default: ;
            endcase
        end
        if (en && we && a == 18'h20000) m_cnt = d;
        else if (tk) m_cnt = m_cnt + 64'd1000;
        @(posedge clk);
        @(negedge clk);
        chk("R2 rvalid", {63'h0, bus_rvalid}, {63'h0, e_rv});
        if (e_rv) chk({e_req, " rdata"}, bus_rdata, e_rd);
        chk("R7 irq", {63'h0, irq}, {63'h0, |(m_status & m_mask)});
        chk("R9 timer_irq", {63'h0, timer_irq},
            {63'h0, m_mask[50] && (m_cnt >= m_cmp)});
    endtask

    task automatic wr(input logic [17:0] a, input logic [63:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [17:0] a);
        cyc(1'b1, 1'b0, a, 64'h0, 1'b0);
    endtask

    task automatic rd_all();
        rd(18'h00020); rd(18'h10000); rd(18'h10018); rd(18'h10030);
        rd(18'h20000); rd(18'h30000);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; tick = 1'b0;
        m_mask = '0; m_status = '0; m_scratch = '0; m_cnt = '0; m_cmp = '0;
        repeat (3) @(negedge clk);
        // R1: reset state of outputs
        chk("R1 irq", {63'h0, irq}, 64'h0);
        chk("R1 timer_irq", {63'h0, timer_irq}, 64'h0);
        chk("R1 rvalid", {63'h0, bus_rvalid}, 64'h0);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        rd_all();

        // R3 mask, R11 scratch, back-to-back reads (R2)
        wr(18'h10000, 64'h0000_00F0_0000_000F);
        wr(18'h10018, 64'hDEAD_BEEF_0123_4567);
        rd(18'h10000); rd(18'h10018); rd(18'h10000);

        // R4 status load, R7 irq
        wr(18'h10020, 64'h0000_0000_0000_0100);      // not enabled
        wr(18'h10020, 64'h8000_0000_0000_0103);      // bits 0,1 enabled
        rd(18'h10020); rd(18'h10028); rd(18'h10030);
        // R5 clear alias
        wr(18'h10028, 64'h0000_0000_0000_0001);
        rd(18'h10030);
        wr(18'h10028, 64'h0000_0000_0000_0002);      // irq falls
        // R6 write-one-to-clear alias
        wr(18'h10020, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(18'h10030, 64'h0000_00F0_0000_000F);
        rd(18'h10030);
        wr(18'h10030, 64'hFFFF_FFFF_FFFF_FFFF);

        // R8 counter: ticks with idle bus, with reads, write priority
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);
        cyc(1'b1, 1'b0, 18'h20000, 64'h0, 1'b1);     // read returns pre-tick value
        rd(18'h20000);
        cyc(1'b1, 1'b1, 18'h20000, 64'h0000_0000_0000_0005, 1'b1);
        rd(18'h20000);
        cyc(1'b1, 1'b1, 18'h10018, 64'h1, 1'b1);     // other write keeps tick
        rd(18'h20000);
        wr(18'h20000, 64'hFFFF_FFFF_FFFF_FF00);       // wrap
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);
        rd(18'h20000);

        // R9 compare boundary, timer enable by mask bit 50
        wr(18'h20000, 64'h0);
        wr(18'h30000, 64'd3000);
        rd(18'h30000);
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);          // reaches 3000, mask off
        wr(18'h10000, 64'h0004_0000_0000_0000);       // bit 50 on
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);          // passed
        wr(18'h30000, 64'd5000);                     // above counter
        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b1);          // equal again
        wr(18'h10000, 64'h0);                        // silence

        // R10 configuration word ignores writes
        wr(18'h00020, 64'h1234_5678_9ABC_DEF0);
        rd(18'h00020);

        // R12 unmapped offsets
        wr(18'h10008, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(18'h20008, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(18'h00021, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(18'h10008); rd(18'h3FFF8);
        rd_all();

        cyc(1'b0, 1'b0, 18'h0, 64'h0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule